// File: doc/BRIEF.md
# Single-Lane Main-Link Symbol Framer

This block builds the symbol stream for one lane of a packetised video main link. It sends two symbols per clock: at a 135 MHz core clock that gives a 270 MHz symbol rate. After reset, and whenever the link is not ready, it sends the idle pattern. This is a periodic blanking-start group that is flagged "no video stream". Once the link has been ready for a configured number of cycles, the block switches cleanly into video, at the start of a vertical-blank line.

In video, each active line is cut into 54-symbol transfer units. Each unit holds 8 pixels of 24-bit colour as 24 data symbols, followed by 30 stuffing symbols. Each line ends with a blanking-start symbol. Four copies of the stream-status byte, the low video time-stamp byte and the low audio time-stamp byte follow it. A blanking-end symbol marks the last symbol before each active line. Every 512th blanking-start is sent as a scrambler-reset instead.

The output is a pair of 8-bit symbols, each with its own control flag, and goes on to a scrambler and an 8b/10b encoder. Pixels are pulled from the source two at a time.

Top module: `mainlink_framer`

## Requirements
- R1: While reset is held, `symOut` is 0, `kOut` is 0 and `pairReq` is low.
- R2: The link-ready input must stay high for at least IDLE_CYC cycles before video starts. Until then the block sends idle groups every IDLE_BS_CYC cycles. In an idle group the status byte is 0x09 (bit 3 = no video stream, bit 0 = vertical blank) and the video time-stamp byte is 0x00.
- R3: `symOut[7:0]` is the symbol sent first on the wire and `symOut[15:8]` is the second; `kOut[i]` flags symbol i as a control symbol. Control codes: blanking-start 0xBC, blanking-end 0xFB, scrambler-reset 0x1C, fill-start 0xFE, fill-end 0xF7.
- R4: Each blanking-start (or scrambler-reset) is followed by 12 data symbols: status byte, video time-stamp byte, audio time-stamp byte, repeated four times in that order. In video the status byte has bit 3 clear, the video time-stamp byte is MVID_VAL (default 0x04), and the audio time-stamp byte is 0x00.
- R5: Blanking-start events are counted from reset starting at 0. Events 0, 512, 1024 and so on are sent as scrambler-reset (0x1C) in place of blanking-start.
- R6: In video, consecutive blanking-start symbols are exactly H_TOTAL_CYC cycles apart (2*H_TOTAL_CYC symbols).
- R7: Each active line carries exactly H_ACT_PIX pixels. Each pixel is sent as R, G, B. `pairReq` takes one pair from `pairData`: `pairData[23:0]` is the earlier pixel and `pairData[47:24]` the later one, each laid out as {R,G,B} with R in the high byte. Pixels go out in the order they were taken. `pairReq` is never high in two cycles in a row.
- R8: A transfer unit is 54 symbols: 24 pixel symbols, then fill-start, 28 zero data symbols, then fill-end.
- R9: Bit 0 of the status byte is set on the blanking-start that ends the last active line and on every blank line; it is clear on all other lines. A blanking-end is sent only as the last symbol before an active line, so none appears during vertical blanking.
- R10: When link-ready drops, the block leaves video at once, returns to idle groups and takes no more pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-pair clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkReady | input | 1 | High once the link is trained and may carry video |
| pairData | input | 48 | Next two pixels from the source |
| pairReq | output | 1 | Takes `pairData` in this cycle |
| symOut | output | 16 | Two symbols, first-sent in the low byte |
| kOut | output | 2 | Control flag for each symbol |

## Verification
Assertions check every cycle for local rules at the output and in the counters. A start or reset symbol must be followed by a data-only pair. A fill-start must be followed by zero data. A blanking-end must be followed by pixel data. Pixel pairs must never be requested back to back. Video may start only after the idle period has run, and must stop as soon as link-ready falls.

Some properties only show up across many lines and frames, so only the bench scenarios can show them. These are: the exact line spacing, the 512-event scrambler-reset cadence, the pixel count and pixel order per line, the stuffing length, the pattern of the vertical-blank flag over a frame, and the length of the idle hand-over.

// File: rtl/mainlink_framer_pkg.sv
package mainlink_framer_pkg;
  localparam logic [7:0] SYM_BS = 8'hBC;
  localparam logic [7:0] SYM_BE = 8'hFB;
  localparam logic [7:0] SYM_SR = 8'h1C;
  localparam logic [7:0] SYM_FS = 8'hFE;
  localparam logic [7:0] SYM_FE = 8'hF7;

  localparam int TU_CYC      = 27;  // 54 symbols per transfer unit
  localparam int TU_DATA_CYC = 12;  // 24 pixel symbols
  localparam int GRP_CYC     = 7;   // start symbol + 12 group symbols + pad

  typedef enum logic [3:0] {
    SL_ZERO, SL_PIX, SL_FS, SL_FE, SL_BE,
    SL_G0, SL_G1, SL_G2, SL_G3, SL_G4, SL_G5, SL_G6
  } slot_e;

  typedef struct packed {
    slot_e      slot;
    logic [1:0] pixPh;
    logic       useSr;
    logic       vblank;
    logic       noVideo;
  } strobe_t;
endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import mainlink_framer_pkg::*;
#(
  parameter int H_ACT_PIX   = 800,
  parameter int H_TOTAL_CYC = 3564,
  parameter int V_ACTIVE    = 600,
  parameter int V_TOTAL     = 628,
  parameter int IDLE_CYC    = 65536,
  parameter int IDLE_BS_CYC = 4096
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    linkReady,
  output strobe_t stb,
  output logic    pairReq
);
  localparam int ACT_CYC = H_ACT_PIX / 8 * TU_CYC;
  localparam int HW = $clog2(H_TOTAL_CYC);
  localparam int VW = $clog2(V_TOTAL);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int PW = $clog2(IDLE_BS_CYC);
  localparam logic [HW-1:0] H_LAST    = HW'(H_TOTAL_CYC - 1);
  localparam logic [HW-1:0] ACT_V     = HW'(ACT_CYC);
  localparam logic [HW-1:0] GRP_H     = HW'(GRP_CYC);
  localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT_V   = VW'(V_ACTIVE);
  localparam logic [VW-1:0] V_ACTM1   = VW'(V_ACTIVE - 1);
  localparam logic [IW-1:0] IDLE_DONE = IW'(IDLE_CYC);
  localparam logic [PW-1:0] P_LAST    = PW'(IDLE_BS_CYC - 1);
  localparam logic [PW-1:0] GRP_P     = PW'(GRP_CYC);

  logic          videoMode;
  logic [IW-1:0] idleElapsed;
  logic [PW-1:0] idlePos;
  logic [HW-1:0] hCnt, grpOff;
  logic [VW-1:0] vCnt;
  logic [4:0]    tuCyc;
  logic [1:0]    pixPh;
  logic [8:0]    srCnt;
  logic          idleDone, lineActive, nextLineActive, startVideo;

  function automatic slot_e grpSlot(input logic [2:0] pos);
    case (pos)
      3'd0:    return SL_G0;
      3'd1:    return SL_G1;
      3'd2:    return SL_G2;
      3'd3:    return SL_G3;
      3'd4:    return SL_G4;
      3'd5:    return SL_G5;
      default: return SL_G6;
    endcase
  endfunction

  assign idleDone       = (idleElapsed == IDLE_DONE);
  assign lineActive     = (vCnt < V_ACT_V) && (hCnt < ACT_V);
  assign nextLineActive = (vCnt == V_LAST) || (vCnt < V_ACTM1);
  assign grpOff         = hCnt - ACT_V;
  assign startVideo     = !videoMode && linkReady && idleDone && (idlePos >= GRP_P);

  always_comb begin
    stb.slot    = SL_ZERO;
    stb.pixPh   = pixPh;
    stb.useSr   = (srCnt == 9'd0);
    stb.vblank  = 1'b1;
    stb.noVideo = !videoMode;
    if (!videoMode) begin
      if (idlePos < GRP_P) stb.slot = grpSlot(3'(idlePos));
    end else begin
      stb.vblank = (vCnt >= V_ACTM1);
      if (lineActive) begin
        if (tuCyc < 5'(TU_DATA_CYC))      stb.slot = SL_PIX;
        else if (tuCyc == 5'(TU_DATA_CYC)) stb.slot = SL_FS;
        else if (tuCyc == 5'(TU_CYC - 1))  stb.slot = SL_FE;
      end else if (grpOff < GRP_H) begin
        stb.slot = grpSlot(3'(grpOff));
      end else if (hCnt == H_LAST && nextLineActive) begin
        stb.slot = SL_BE;
      end
    end
  end

  assign pairReq = videoMode && (stb.slot == SL_PIX) && (pixPh == 2'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      videoMode   <= 1'b0;
      idleElapsed <= '0;
      idlePos     <= '0;
      hCnt        <= '0;
      vCnt        <= '0;
      tuCyc       <= '0;
      pixPh       <= '0;
      srCnt       <= '0;
    end else begin
      if (!linkReady)     idleElapsed <= '0;
      else if (!idleDone) idleElapsed <= idleElapsed + 1'b1;
      idlePos <= (idlePos == P_LAST) ? '0 : idlePos + 1'b1;
      if (stb.slot == SL_G0) srCnt <= srCnt + 9'd1;
      if (!linkReady) begin
        videoMode <= 1'b0;
      end else if (startVideo) begin
        videoMode <= 1'b1;
        hCnt      <= '0;
        vCnt      <= V_ACT_V;
        tuCyc     <= '0;
        pixPh     <= '0;
      end else if (videoMode) begin
        if (hCnt == H_LAST) begin
          hCnt <= '0;
          vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
        end else begin
          hCnt <= hCnt + 1'b1;
        end
        if (lineActive) tuCyc <= (tuCyc == 5'(TU_CYC - 1)) ? 5'd0 : tuCyc + 5'd1;
        else            tuCyc <= '0;
        if (stb.slot == SL_PIX) pixPh <= (pixPh == 2'd2) ? 2'd0 : pixPh + 2'd1;
        else                    pixPh <= '0;
      end
    end
  end

  // R2
  idle_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(videoMode) |-> ($past(idleDone) && $past(linkReady)));

  // R7
  pair_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairReq |-> !$past(pairReq));

  // R10
  drop_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkReady |=> (!videoMode && !pairReq));
endmodule

// File: rtl/framer_dp.sv
module framer_dp
  import mainlink_framer_pkg::*;
#(
  parameter logic [7:0] MVID_VAL = 8'h04
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [47:0] pairData,
  output logic [15:0] symOut,
  output logic [1:0]  kOut
);
  logic [47:0] pairHold, pairNow;
  logic [7:0]  vbid, mvid, lo, hi;
  logic        kLo, kHi, takePair;

  assign takePair = (stb.slot == SL_PIX) && (stb.pixPh == 2'd0);
  assign pairNow  = takePair ? pairData : pairHold;
  assign vbid     = {4'b0, stb.noVideo, 2'b0, stb.vblank};
  assign mvid     = stb.noVideo ? 8'h00 : MVID_VAL;

  always_comb begin
    lo = 8'h00; hi = 8'h00; kLo = 1'b0; kHi = 1'b0;
    case (stb.slot)
      SL_PIX: begin
        case (stb.pixPh)
          2'd0:    begin lo = pairNow[23:16]; hi = pairNow[15:8];  end
          2'd1:    begin lo = pairNow[7:0];   hi = pairNow[47:40]; end
          default: begin lo = pairNow[39:32]; hi = pairNow[31:24]; end
        endcase
      end
      SL_FS:        begin lo = SYM_FS; kLo = 1'b1; end
      SL_FE:        begin hi = SYM_FE; kHi = 1'b1; end
      SL_BE:        begin hi = SYM_BE; kHi = 1'b1; end
      SL_G0:        begin lo = stb.useSr ? SYM_SR : SYM_BS; kLo = 1'b1; hi = vbid; end
      SL_G1, SL_G4: begin lo = mvid; hi = 8'h00; end
      SL_G2, SL_G5: begin lo = vbid; hi = mvid;  end
      SL_G3:        begin lo = 8'h00; hi = vbid; end
      SL_G6:        begin lo = 8'h00; hi = 8'h00; end
      default:      ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairHold <= '0;
      symOut   <= '0;
      kOut     <= '0;
    end else begin
      if (takePair) pairHold <= pairData;
      symOut <= {hi, lo};
      kOut   <= {kHi, kLo};
    end
  end

  // R4
  grp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kOut[0] && (symOut[7:0] == SYM_BS || symOut[7:0] == SYM_SR)) |=> (kOut == 2'b00));

  // R8
  fill_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kOut[0] && symOut[7:0] == SYM_FS) |=> (kOut == 2'b00 && symOut == 16'h0000));

  // R9
  be_then_pix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kOut[1] && symOut[15:8] == SYM_BE) |=> (kOut == 2'b00));
endmodule

// File: rtl/mainlink_framer.sv
module mainlink_framer
  import mainlink_framer_pkg::*;
#(
  parameter int         H_ACT_PIX   = 800,
  parameter int         H_TOTAL_CYC = 3564,
  parameter int         V_ACTIVE    = 600,
  parameter int         V_TOTAL     = 628,
  parameter int         IDLE_CYC    = 65536,
  parameter int         IDLE_BS_CYC = 4096,
  parameter logic [7:0] MVID_VAL    = 8'h04
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        linkReady,
  input  logic [47:0] pairData,
  output logic        pairReq,
  output logic [15:0] symOut,
  output logic [1:0]  kOut
);
  strobe_t stb;

  framer_ctrl #(
    .H_ACT_PIX(H_ACT_PIX), .H_TOTAL_CYC(H_TOTAL_CYC), .V_ACTIVE(V_ACTIVE),
    .V_TOTAL(V_TOTAL), .IDLE_CYC(IDLE_CYC), .IDLE_BS_CYC(IDLE_BS_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .stb(stb), .pairReq(pairReq)
  );

  framer_dp #(.MVID_VAL(MVID_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pairData(pairData),
    .symOut(symOut), .kOut(kOut)
  );
endmodule

// File: tb/tb_mainlink_framer.sv
module tb_mainlink_framer;
  localparam int HP = 16, HT = 90, VA = 4, VT = 6, IC = 300, IBC = 64;
  localparam int ACT = HP / 8 * 27;

  logic        clk = 1'b0, rstN = 1'b0, linkReady = 1'b0;
  logic [47:0] pairData;
  logic        pairReq;
  logic [15:0] symOut;
  logic [1:0]  kOut;

  always #5 clk = ~clk;

  mainlink_framer #(.H_ACT_PIX(HP), .H_TOTAL_CYC(HT), .V_ACTIVE(VA), .V_TOTAL(VT),
    .IDLE_CYC(IC), .IDLE_BS_CYC(IBC), .MVID_VAL(8'h04)) dut (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .pairData(pairData),
    .pairReq(pairReq), .symOut(symOut), .kOut(kOut));

  int checks = 0, errors = 0, cyc = 0;

  // pixel source
  int srcPix = 0;
  function automatic logic [23:0] pix(input int n);
    logic [7:0] b = n[7:0];
    return {b, b ^ 8'hA5, b + 8'd3};
  endfunction
  assign pairData = {pix(srcPix + 1), pix(srcPix)};
  always @(posedge clk) if (!rstN) srcPix <= 0; else if (pairReq) srcPix <= srcPix + 2;

  function automatic logic [7:0] expByte(input int m);
    logic [23:0] p = pix(m / 3);
    case (m % 3)
      0:       return p[23:16];
      1:       return p[15:8];
      default: return p[7:0];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stream parser
  int symIdx = 0, bsIdx = 0, grpIdx = 0, lastBsSym = 0;
  int prevVidBs = -1, firstVidBs = -1, prevIdleBs = -1, vidBsCnt = 0;
  int srErr = 0, grpErr = 0, spaceErr = 0, idleErr = 0, pixErr = 0, valErr = 0;
  int fillErr = 0, vbErr = 0, beErr = 0, lines = 0, mByte = 0;
  int fillCnt = 0, pixInLine = 0, zeroRun = 0, oneRun = 0;
  bit inLine = 0, inFill = 0, lastVb = 0, firstOneRun = 0;
  logic [7:0] grpVbid = 8'h00;

  task automatic onVbid(input logic [7:0] v);
    if (v[3]) begin
      if (v != 8'h09) grpErr++;
      if (prevIdleBs >= 0 && lastBsSym - prevIdleBs != 2 * IBC) idleErr++;
      prevIdleBs = lastBsSym;
    end else begin
      prevIdleBs = -1;
      if (v[7:1] != 7'd0) grpErr++;
      if (firstVidBs < 0) firstVidBs = lastBsSym;
      if (prevVidBs >= 0 && lastBsSym - prevVidBs != 2 * HT) spaceErr++;
      prevVidBs = lastBsSym;
      vidBsCnt++;
      if (vidBsCnt == 1) begin
        if (!v[0]) vbErr++;
        oneRun = 1; firstOneRun = 1;
      end else if (v[0]) begin
        if (!lastVb) begin
          if (zeroRun != VA - 1) vbErr++;
          oneRun = 1;
        end else oneRun++;
      end else begin
        if (lastVb) begin
          if (oneRun != (firstOneRun ? VT - VA : VT - VA + 1)) vbErr++;
          firstOneRun = 0; zeroRun = 1;
        end else zeroRun++;
      end
      lastVb = v[0];
    end
  endtask

  task automatic procSym(input logic [7:0] b, input logic k);
    if (k && (b == 8'hBC || b == 8'h1C)) begin
      if ((bsIdx % 512 == 0) != (b == 8'h1C)) srErr++;
      bsIdx++;
      if (inLine) begin
        if (pixInLine != HP * 3) pixErr++;
        lines++; inLine = 0;
      end
      if (inFill) fillErr++;
      grpIdx = 1; lastBsSym = symIdx;
    end else if (grpIdx > 0) begin
      if (k) grpErr++;
      case (grpIdx % 3)
        1: if (grpIdx == 1) grpVbid = b; else if (b != grpVbid) grpErr++;
        2: if (b != (grpVbid[3] ? 8'h00 : 8'h04)) grpErr++;
        default: if (b != 8'h00) grpErr++;
      endcase
      if (grpIdx == 1) onVbid(b);
      grpIdx = (grpIdx == 12) ? 0 : grpIdx + 1;
    end else if (k && b == 8'hFB) begin
      if (grpVbid[3] || (lastVb && oneRun != (firstOneRun ? VT - VA : VT - VA + 1))) beErr++;
      inLine = 1; pixInLine = 0;
    end else if (k && b == 8'hFE) begin
      if (inFill || !inLine) fillErr++;
      inFill = 1; fillCnt = 1;
    end else if (k && b == 8'hF7) begin
      fillCnt++;
      if (!inFill || fillCnt != 30) fillErr++;
      inFill = 0;
    end else if (k) begin
      grpErr++;
    end else if (inFill) begin
      fillCnt++;
      if (b != 8'h00) fillErr++;
    end else if (inLine) begin
      if (b != expByte(mByte)) valErr++;
      mByte++; pixInLine++;
    end else if (b != 8'h00) begin
      grpErr++;
    end
    symIdx++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      procSym(symOut[7:0], kOut[0]);
      procSym(symOut[15:8], kOut[1]);
    end
  end

  bit monOn = 0, reqSeen = 0;
  always @(posedge clk) if (monOn && pairReq) reqSeen = 1;

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(symOut == 16'h0, "R1 symOut in reset", int'(symOut), 0);
    check(kOut == 2'b00, "R1 kOut in reset", int'(kOut), 0);
    check(pairReq == 1'b0, "R1 pairReq in reset", int'(pairReq), 0);
    rstN <= 1'b1;
  endtask

  task automatic t_idle();
    int riseSym, d;
    repeat (200) @(negedge clk);
    check(bsIdx >= 3, "R2 idle groups before ready", bsIdx, 3);
    check(firstVidBs < 0, "R2 no video while not ready", firstVidBs, -1);
    linkReady <= 1'b1;
    riseSym = symIdx;
    for (int g = 0; g < 5000 && firstVidBs < 0; g++) @(negedge clk);
    d = firstVidBs - riseSym;
    check(d >= 2 * (IC + ACT), "R2 idle hold length min", d, 2 * (IC + ACT));
    check(d <= 2 * (IC + IBC + ACT + 4), "R2 idle hold length max", d, 2 * (IC + IBC + ACT + 4));
    check(idleErr == 0, "R2 idle group spacing", idleErr, 0);
  endtask

  task automatic t_video();
    for (int g = 0; g < 100000 && bsIdx < 530; g++) @(negedge clk);
    check(bsIdx >= 530, "R5 reached 512+ start events", bsIdx, 530);
    check(srErr == 0, "R5 scrambler-reset cadence", srErr, 0);
    check(grpErr == 0, "R3 R4 group contents and codes", grpErr, 0);
    check(spaceErr == 0, "R6 line spacing", spaceErr, 0);
    check(pixErr == 0, "R7 pixels per line", pixErr, 0);
    check(lines >= 300, "R7 active lines seen", lines, 300);
    check(valErr == 0, "R7 pixel order and values", valErr, 0);
    check(fillErr == 0, "R8 transfer-unit stuffing", fillErr, 0);
    check(vbErr == 0, "R9 vertical-blank flag pattern", vbErr, 0);
    check(beErr == 0, "R9 blanking-end placement", beErr, 0);
  endtask

  task automatic t_drop();
    int bsBefore = bsIdx;
    linkReady <= 1'b0;
    repeat (2) @(negedge clk);
    monOn = 1;
    repeat (2 * IBC + 20) @(negedge clk);
    monOn = 0;
    check(!reqSeen, "R10 no pixel pulls after drop", int'(reqSeen), 0);
    check(bsIdx > bsBefore, "R10 groups resume after drop", bsIdx, bsBefore + 1);
    check(grpVbid == 8'h09, "R10 idle status byte after drop", int'(grpVbid), 9);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_video();
    t_drop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule